// File: doc/BRIEF.md
# CPU-to-PCI Bridge Window Translator

This block sits on the CPU side of a small host-to-PCI bridge as a bus slave. It claims three CPU address ranges. The first is a control window. It holds a 256-byte local configuration header, three translation registers and a data port for indirect configuration cycles. The second is a 16 MiB memory window and the third is a 256 KiB I/O window. Each is relocated downstream by a programmable base.

Each claimed access that must leave the block becomes one downstream request, which is held until it is acknowledged. The request carries a kind (configuration, memory or I/O), a translated address, the byte size and, for writes, the data. Register accesses are served locally. Addresses outside all three ranges get an error response.

The CPU holds `cpu_valid` and its fields stable until `cpu_done` pulses for one cycle. It then drops `cpu_valid` before the next rising edge.

Top module: `hb_window_xlate`

## Requirements
- R1: After reset, header word 0 reads 0x350E1054 and header word 1 reads 0x02900080 (header bytes 0..7 are 54 10 0E 35 80 00 90 02, byte k in bits 8k+7:8k). Every other header word and the three translation registers read as zero.
- R2: The control window starts at 0x1E200000 and is 0x224 bytes long. A 4-byte access at offsets 0x000..0x0FC writes or reads header word (offset>>2). The two low offset bits are ignored in the control window.
- R3: Offset 0x1C0 is the configuration pointer, which can be both written and read back.
- R4: Offset 0x1C4 (memory base) and offset 0x1C8 (I/O base) accept writes but read as zero. Other unused offsets read zero, and writes to them change nothing.
- R5: A 4-byte read or write at offset 0x220 issues a downstream request of kind 0 (configuration) and size code 2. Its address is the current pointer value. The data returned with the acknowledge becomes the read data.
- R6: An access at CPU address A in 0xFD000000..0xFDFFFFFF issues kind 1 (memory) with address A − 0xFD000000 + memory base.
- R7: An access at A in 0x1E240000..0x1E27FFFF issues kind 2 (I/O) with address A − 0x1E240000 + I/O base.
- R8: The size code is 0 for 1 byte, 1 for 2 bytes and 2 for 4 bytes. Memory and I/O accesses pass the size code through unchanged.
- R9: Only one downstream request is outstanding at a time. `dn_req` and its fields stay stable until `dn_ack`, and `cpu_done` follows one cycle after the acknowledge.
- R10: A control-window access whose size is not 4 bytes completes one cycle after it is presented. It has no effect, returns zero data and issues no downstream request.
- R11: Any other access gets `cpu_done` with `cpu_err` high and zero data, and issues no downstream request. This covers an address outside the three windows, and size code 3 in the memory or I/O window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cpu_valid | input | 1 | CPU access presented, held until done |
| cpu_write | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | 32 | CPU byte address |
| cpu_size | input | 2 | Size code: 0 = 1 B, 1 = 2 B, 2 = 4 B |
| cpu_wdata | input | 32 | CPU write data |
| cpu_done | output | 1 | One-cycle completion pulse |
| cpu_err | output | 1 | Error response, valid with cpu_done |
| cpu_rdata | output | 32 | Read data, valid with cpu_done |
| dn_req | output | 1 | Downstream request, held until dn_ack |
| dn_kind | output | 2 | 0 = configuration, 1 = memory, 2 = I/O |
| dn_addr | output | 32 | Translated downstream address |
| dn_size | output | 2 | Size code of the downstream access |
| dn_write | output | 1 | Downstream write |
| dn_wdata | output | 32 | Downstream write data |
| dn_ack | input | 1 | Downstream completion |
| dn_rdata | input | 32 | Downstream read data, valid with dn_ack |

## Verification
Register traffic is tried with words at both ends of the header, with the pointer, and with the two write-only bases. This separates a readable register from a hidden one and from an unused offset. Downstream traffic uses each window with all three sizes, including the first and last words of a window, after both bases are set to non-zero values. This catches a missing subtraction, a missing addition or a swapped base. Narrow accesses to the control window and addresses just past each window end show that no request leaks out and that the error path works. A cycle-level model in the bench flags any `dn_req` or `cpu_done` that appears when no request or completion is expected.

// File: rtl/hb_pkg.sv
// Package: shared encodings and reset contents for the bridge window translator.
// Assumes a 32-bit CPU address and data path.
package hb_pkg;
    typedef enum logic [1:0] {DK_CFG = 2'd0, DK_MEM = 2'd1, DK_IO = 2'd2} dn_kind_e;

    localparam logic [1:0] SZ_BYTE = 2'd0;
    localparam logic [1:0] SZ_HALF = 2'd1;
    localparam logic [1:0] SZ_WORD = 2'd2;

    localparam logic [11:0] OFS_HDR_LAST = 12'h0FC;
    localparam logic [11:0] OFS_PTR      = 12'h1C0;
    localparam logic [11:0] OFS_MBASE    = 12'h1C4;
    localparam logic [11:0] OFS_IOBASE   = 12'h1C8;
    localparam logic [11:0] OFS_CFGPORT  = 12'h220;

    // Reset value of a header word; bytes are little-endian within the word.
    function automatic logic [31:0] hdr_reset_word(input int idx);
        case (idx)
            0:       return 32'h350E_1054;
            1:       return 32'h0290_0080;
            default: return 32'h0;
        endcase
    endfunction
endpackage

// File: rtl/hb_decode.sv
// Module: address decode and translation for the three CPU windows.
// Purely combinational. Assumes the windows do not overlap.
module hb_decode #(
    parameter logic [31:0] REG_BASE = 32'h1E20_0000,
    parameter int unsigned REG_SPAN = 32'h224,
    parameter logic [31:0] MEM_BASE = 32'hFD00_0000,
    parameter int unsigned MEM_SPAN = 32'h0100_0000,
    parameter logic [31:0] IO_BASE  = 32'h1E24_0000,
    parameter int unsigned IO_SPAN  = 32'h0004_0000
) (
    input  logic [31:0] addr,
    input  logic [31:0] mem_base_reg,
    input  logic [31:0] io_base_reg,
    output logic        hit_reg,
    output logic        hit_mem,
    output logic        hit_io,
    output logic [11:0] reg_ofs,
    output logic [31:0] mem_dn_addr,
    output logic [31:0] io_dn_addr
);
    logic [31:0] rel_reg, rel_mem, rel_io;

    // Window offsets and range hits.
    always_comb begin
        rel_reg = addr - REG_BASE;
        rel_mem = addr - MEM_BASE;
        rel_io  = addr - IO_BASE;
        hit_reg = (addr >= REG_BASE) && (rel_reg < REG_SPAN);
        hit_mem = (addr >= MEM_BASE) && (rel_mem < MEM_SPAN);
        hit_io  = (addr >= IO_BASE)  && (rel_io  < IO_SPAN);
        reg_ofs = rel_reg[11:0];
    end

    // Relocation by the programmed downstream bases.
    always_comb begin
        mem_dn_addr = rel_mem + mem_base_reg;
        io_dn_addr  = rel_io  + io_base_reg;
    end
endmodule

// File: rtl/hb_regfile.sv
// Module: local configuration header and the three translation registers.
// Only whole 32-bit words are written. The memory and I/O bases are write-only.
module hb_regfile #(
    parameter int HDR_BYTES = 256
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_en,
    input  logic [11:0] ofs,
    input  logic [31:0] wdata,
    output logic [31:0] rd_data,
    output logic [31:0] ptr,
    output logic [31:0] mem_base,
    output logic [31:0] io_base
);
    import hb_pkg::*;
    localparam int HDR_WORDS = HDR_BYTES / 4;
    localparam int IDX_W     = $clog2(HDR_WORDS);

    logic [31:0] hdr [HDR_WORDS];
    logic [9:0]  word_ofs;
    logic        in_hdr;

    assign word_ofs = ofs[11:2];
    assign in_hdr   = (word_ofs <= OFS_HDR_LAST[11:2]);

    // One register per header word, each with its own reset value.
    for (genvar g = 0; g < HDR_WORDS; g++) begin : g_hdr
        always_ff @(posedge clk) begin
            if (!rst_n)
                hdr[g] <= hdr_reset_word(g);
            else if (wr_en && in_hdr && word_ofs[IDX_W-1:0] == IDX_W'(g))
                hdr[g] <= wdata;
        end
    end

    // Translation registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr      <= '0;
            mem_base <= '0;
            io_base  <= '0;
        end else if (wr_en) begin
            if (word_ofs == OFS_PTR[11:2])    ptr      <= wdata;
            if (word_ofs == OFS_MBASE[11:2])  mem_base <= wdata;
            if (word_ofs == OFS_IOBASE[11:2]) io_base  <= wdata;
        end
    end

    // Read map: header and pointer are visible, everything else reads zero.
    always_comb begin
        if (in_hdr)                           rd_data = hdr[word_ofs[IDX_W-1:0]];
        else if (word_ofs == OFS_PTR[11:2])   rd_data = ptr;
        else                                  rd_data = '0;
    end

    // R3: the pointer only changes on a register write.
    p_ptr_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(ptr));
endmodule

// File: rtl/hb_window_xlate.sv
// Module: top of the bridge window translator. It decodes the CPU access,
// serves register-window accesses locally, and forwards configuration, memory
// and I/O accesses as one held downstream request. Assumes the CPU holds
// cpu_valid and its fields until cpu_done, and that dn_ack comes only while
// dn_req is high.
module hb_window_xlate #(
    parameter logic [31:0] REG_BASE  = 32'h1E20_0000,
    parameter int unsigned REG_SPAN  = 32'h224,
    parameter logic [31:0] MEM_BASE  = 32'hFD00_0000,
    parameter int unsigned MEM_SPAN  = 32'h0100_0000,
    parameter logic [31:0] IO_BASE   = 32'h1E24_0000,
    parameter int unsigned IO_SPAN   = 32'h0004_0000,
    parameter int          HDR_BYTES = 256
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cpu_valid,
    input  logic        cpu_write,
    input  logic [31:0] cpu_addr,
    input  logic [1:0]  cpu_size,
    input  logic [31:0] cpu_wdata,
    output logic        cpu_done,
    output logic        cpu_err,
    output logic [31:0] cpu_rdata,
    output logic        dn_req,
    output logic [1:0]  dn_kind,
    output logic [31:0] dn_addr,
    output logic [1:0]  dn_size,
    output logic        dn_write,
    output logic [31:0] dn_wdata,
    input  logic        dn_ack,
    input  logic [31:0] dn_rdata
);
    import hb_pkg::*;

    typedef enum logic [1:0] {ST_IDLE, ST_WAIT, ST_DONE} state_e;
    state_e state;

    logic        hit_reg, hit_mem, hit_io;
    logic [11:0] reg_ofs;
    logic [31:0] mem_dn_addr, io_dn_addr;
    logic [31:0] rf_rdata, ptr, mem_base, io_base;
    logic        accept, is_word, is_cfgport, rf_we;
    logic [31:0] rdata_q;
    logic        err_q;

    hb_decode #(
        .REG_BASE(REG_BASE), .REG_SPAN(REG_SPAN),
        .MEM_BASE(MEM_BASE), .MEM_SPAN(MEM_SPAN),
        .IO_BASE(IO_BASE),   .IO_SPAN(IO_SPAN)
    ) u_dec (
        .addr(cpu_addr), .mem_base_reg(mem_base), .io_base_reg(io_base),
        .hit_reg(hit_reg), .hit_mem(hit_mem), .hit_io(hit_io),
        .reg_ofs(reg_ofs), .mem_dn_addr(mem_dn_addr), .io_dn_addr(io_dn_addr)
    );

    hb_regfile #(.HDR_BYTES(HDR_BYTES)) u_rf (
        .clk(clk), .rst_n(rst_n), .wr_en(rf_we), .ofs(reg_ofs),
        .wdata(cpu_wdata), .rd_data(rf_rdata),
        .ptr(ptr), .mem_base(mem_base), .io_base(io_base)
    );

    // Acceptance and local register write strobe.
    always_comb begin
        accept     = (state == ST_IDLE) && cpu_valid;
        is_word    = (cpu_size == SZ_WORD);
        is_cfgport = (reg_ofs[11:2] == OFS_CFGPORT[11:2]);
        rf_we      = accept && hit_reg && is_word && cpu_write && !is_cfgport;
    end

    // Access sequencer and downstream request register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            dn_req   <= 1'b0;
            dn_kind  <= DK_CFG;
            dn_addr  <= '0;
            dn_size  <= SZ_BYTE;
            dn_write <= 1'b0;
            dn_wdata <= '0;
            rdata_q  <= '0;
            err_q    <= 1'b0;
        end else begin
            case (state)
                ST_IDLE: if (cpu_valid) begin
                    dn_write <= cpu_write;
                    dn_wdata <= cpu_wdata;
                    dn_size  <= cpu_size;
                    if (hit_reg && is_word && is_cfgport) begin
                        dn_req  <= 1'b1;
                        dn_kind <= DK_CFG;
                        dn_addr <= ptr;
                        state   <= ST_WAIT;
                    end else if (hit_reg) begin
                        rdata_q <= (is_word && !cpu_write) ? rf_rdata : 32'h0;
                        err_q   <= 1'b0;
                        state   <= ST_DONE;
                    end else if ((hit_mem || hit_io) && cpu_size != 2'd3) begin
                        dn_req  <= 1'b1;
                        dn_kind <= hit_mem ? DK_MEM : DK_IO;
                        dn_addr <= hit_mem ? mem_dn_addr : io_dn_addr;
                        state   <= ST_WAIT;
                    end else begin
                        rdata_q <= '0;
                        err_q   <= 1'b1;
                        state   <= ST_DONE;
                    end
                end
                ST_WAIT: if (dn_ack) begin
                    dn_req  <= 1'b0;
                    rdata_q <= dn_write ? 32'h0 : dn_rdata;
                    err_q   <= 1'b0;
                    state   <= ST_DONE;
                end
                default: begin
                    rdata_q <= '0;
                    err_q   <= 1'b0;
                    state   <= ST_IDLE;
                end
            endcase
        end
    end

    // CPU-side response.
    assign cpu_done  = (state == ST_DONE);
    assign cpu_err   = cpu_done && err_q;
    assign cpu_rdata = rdata_q;

    // R9: a pending request keeps all of its fields until acknowledged.
    p_req_stable_r9: assert property (@(posedge clk) disable iff (!rst_n)
        dn_req && !dn_ack |=> dn_req && $stable(dn_addr) && $stable(dn_kind)
                               && $stable(dn_size) && $stable(dn_wdata));
    // R9: completion is a single-cycle pulse and never overlaps a request.
    p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_done |-> !dn_req ##1 !cpu_done);
    // R9: the acknowledge of a request is followed by completion.
    p_ack_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
        dn_req && dn_ack |=> cpu_done && !dn_req);
    // R10: a narrow control-window access never leaves the block.
    p_narrow_local_r10: assert property (@(posedge clk) disable iff (!rst_n)
        accept && hit_reg && !is_word |=> cpu_done && !dn_req && cpu_rdata == 32'h0);
    // R11: an error carries zero data.
    p_err_zero_r11: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_err |-> cpu_rdata == 32'h0);
    // R11: at most one window claims an address.
    p_one_window_r11: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_valid |-> $onehot0({hit_reg, hit_mem, hit_io}));
endmodule

// File: tb/sim_hb_window_xlate.sv
module sim_hb_window_xlate;
    logic clk = 0, rst_n = 0;
    logic cpu_valid = 0, cpu_write = 0;
    logic [31:0] cpu_addr = 0, cpu_wdata = 0;
    logic [1:0] cpu_size = 0;
    logic cpu_done, cpu_err, dn_req, dn_write;
    logic [31:0] cpu_rdata, dn_addr, dn_wdata;
    logic [1:0] dn_kind, dn_size;
    logic dn_ack = 0;
    logic [31:0] dn_rdata = 0;

    int n_checks = 0, n_fail = 0;
    bit m_in_access = 0, m_dn_expected = 0;

    // Behavioural model state.
    logic [31:0] m_hdr [64];
    logic [31:0] m_ptr, m_mbase, m_iobase;

    // Results of the last access.
    logic [31:0] r_data;
    logic r_err, r_saw;
    int r_cyc;
    logic [1:0] g_kind, g_size;
    logic [31:0] g_addr, g_wdata;
    logic g_wr;

    always #5 clk = ~clk;

    hb_window_xlate u0 (.*);

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Per-cycle comparison against the model's expectation of activity.
    always @(posedge clk) begin
        #1;
        if (rst_n) begin
            if (dn_req && !m_dn_expected) check("R9 unexpected dn_req", 1, 0);
            if (cpu_done && !m_in_access) check("R9 unexpected cpu_done", 1, 0);
        end
    end

    initial begin
        #1_000_000;
        n_fail++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    task automatic access(input logic wr, input logic [31:0] a, input logic [1:0] sz,
                          input logic [31:0] wd, input logic exp_dn, input logic [31:0] ack_val);
        int ackcnt = 0;
        bit sent = 0;
        cpu_valid = 1; cpu_write = wr; cpu_addr = a; cpu_size = sz; cpu_wdata = wd;
        m_in_access = 1; m_dn_expected = exp_dn;
        r_cyc = 0; r_saw = 0;
        forever begin
            @(negedge clk);
            r_cyc++;
            if (cpu_done) begin
                r_data = cpu_rdata; r_err = cpu_err; cpu_valid = 0; dn_ack = 0;
                break;
            end
            if (dn_req && !sent) begin
                if (!r_saw) begin
                    g_kind = dn_kind; g_addr = dn_addr; g_size = dn_size;
                    g_wr = dn_write; g_wdata = dn_wdata;
                end
                r_saw = 1;
                ackcnt++;
                if (ackcnt == 2) begin dn_ack = 1; dn_rdata = ack_val; sent = 1; end
            end
            if (r_cyc > 40) begin
                check("R9 access hung", 0, 1);
                cpu_valid = 0; dn_ack = 0;
                break;
            end
        end
        @(negedge clk);
        m_in_access = 0; m_dn_expected = 0;
    endtask

    // Expected register read from the model.
    function automatic logic [31:0] m_read(input logic [11:0] ofs);
        if (ofs[11:2] <= 10'h3F) return m_hdr[ofs[7:2]];
        if (ofs[11:2] == 10'h70) return m_ptr;
        return 32'h0;
    endfunction

    task automatic m_write(input logic [11:0] ofs, input logic [31:0] v);
        if (ofs[11:2] <= 10'h3F) m_hdr[ofs[7:2]] = v;
        else if (ofs[11:2] == 10'h70) m_ptr = v;
        else if (ofs[11:2] == 10'h71) m_mbase = v;
        else if (ofs[11:2] == 10'h72) m_iobase = v;
    endtask

    task automatic reg_wr(input logic [11:0] ofs, input logic [31:0] v);
        access(1, 32'h1E20_0000 + ofs, 2, v, 0, 0);
        m_write(ofs, v);
    endtask

    task automatic reg_rd_check(input string req, input logic [11:0] ofs);
        access(0, 32'h1E20_0000 + ofs, 2, 0, 0, 0);
        check(req, r_data, m_read(ofs));
        check({req, " no downstream"}, r_saw, 0);
        check({req, " local latency"}, r_cyc, 1);
    endtask

    task automatic dn_check(input string req, input logic wr, input logic [31:0] a,
                            input logic [1:0] sz, input logic [31:0] wd,
                            input logic [1:0] ek, input logic [31:0] ea,
                            input logic [31:0] ackv);
        access(wr, a, sz, wd, 1, ackv);
        check({req, " issued"}, r_saw, 1);
        check({req, " kind"}, g_kind, ek);
        check({req, " addr"}, g_addr, ea);
        check({req, " size"}, g_size, sz);
        check({req, " dir"}, g_wr, wr);
        if (wr) check({req, " wdata"}, g_wdata, wd);
        check({req, " rdata"}, r_data, wr ? 32'h0 : ackv);
        check({req, " R9 latency"}, r_cyc, 3);
        check({req, " err"}, r_err, 0);
    endtask

    initial begin
        for (int i = 0; i < 64; i++) m_hdr[i] = 32'h0;
        m_hdr[0] = 32'h350E_1054; m_hdr[1] = 32'h0290_0080;
        m_ptr = 0; m_mbase = 0; m_iobase = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);

        // R1: reset contents.
        check("R1 done idle", cpu_done, 0);
        check("R1 req idle", dn_req, 0);
        reg_rd_check("R1 hdr word0", 12'h000);
        reg_rd_check("R1 hdr word1", 12'h004);
        reg_rd_check("R1 hdr word2", 12'h008);
        reg_rd_check("R1 ptr", 12'h1C0);
        dn_check("R1 zero bases mem", 0, 32'hFD00_0100, 2, 0, 2'd1, 32'h0000_0100, 32'h1111_2222);

        // R2: header read/write at both ends, low offset bits ignored.
        reg_wr(12'h010, 32'hDEAD_BEEF);
        reg_rd_check("R2 hdr 0x010", 12'h010);
        reg_wr(12'h0FC, 32'hA5A5_0F0F);
        reg_rd_check("R2 hdr 0x0FC", 12'h0FC);
        reg_wr(12'h000, 32'h1234_5678);
        reg_rd_check("R2 hdr 0x000", 12'h000);
        access(0, 32'h1E20_0013, 2, 0, 0, 0);
        check("R2 unaligned word ofs", r_data, 32'hDEAD_BEEF);

        // R3: pointer.
        reg_wr(12'h1C0, 32'h8000_1234);
        reg_rd_check("R3 ptr", 12'h1C0);

        // R4: write-only bases and unused offsets.
        reg_wr(12'h1C4, 32'h4000_0000);
        reg_rd_check("R4 mbase hidden", 12'h1C4);
        reg_wr(12'h1C8, 32'h0000_1000);
        reg_rd_check("R4 iobase hidden", 12'h1C8);
        access(1, 32'h1E20_0100, 2, 32'hFFFF_FFFF, 0, 0);
        reg_rd_check("R4 unused 0x100", 12'h100);
        reg_rd_check("R4 ptr kept", 12'h1C0);
        reg_rd_check("R4 hdr kept", 12'h0FC);

        // R5: configuration port.
        dn_check("R5 cfg read", 0, 32'h1E20_0220, 2, 0, 2'd0, 32'h8000_1234, 32'hCAFE_F00D);
        dn_check("R5 cfg write", 1, 32'h1E20_0220, 2, 32'h0BAD_C0DE, 2'd0, 32'h8000_1234, 0);

        // R6/R8: memory window.
        dn_check("R6 mem word", 0, 32'hFD00_0010, 2, 0, 2'd1, 32'h4000_0010, 32'h7777_0001);
        dn_check("R6 R8 mem half end", 1, 32'hFDFF_FFFE, 1, 32'h0000_BEEF, 2'd1, 32'h40FF_FFFE, 0);
        dn_check("R6 R8 mem byte start", 0, 32'hFD00_0000, 0, 0, 2'd1, 32'h4000_0000, 32'h0000_00AB);

        // R7/R8: I/O window.
        dn_check("R7 R8 io byte", 0, 32'h1E24_0003, 0, 0, 2'd2, 32'h0000_1003, 32'h0000_005A);
        dn_check("R7 R8 io word end", 1, 32'h1E27_FFFC, 2, 32'h1357_9BDF, 2'd2, 32'h0004_0FFC, 0);
        dn_check("R7 R8 io half", 0, 32'h1E24_0100, 1, 0, 2'd2, 32'h0000_1100, 32'h0000_4321);

        // R10: narrow control-window accesses do nothing.
        access(1, 32'h1E20_01C0, 1, 32'h1111_1111, 0, 0);
        check("R10 narrow write latency", r_cyc, 1);
        check("R10 narrow write no dn", r_saw, 0);
        check("R10 narrow write err", r_err, 0);
        reg_rd_check("R10 ptr unchanged", 12'h1C0);
        access(0, 32'h1E20_0000, 0, 0, 0, 0);
        check("R10 narrow read zero", r_data, 0);
        access(0, 32'h1E20_0220, 1, 0, 0, 0);
        check("R10 narrow cfg port no dn", r_saw, 0);
        check("R10 narrow cfg port zero", r_data, 0);

        // R11: outside all windows, and size code 3.
        access(0, 32'h1E20_0224, 2, 0, 0, 0);
        check("R11 past ctrl err", r_err, 1);
        check("R11 past ctrl no dn", r_saw, 0);
        check("R11 past ctrl data", r_data, 0);
        access(1, 32'h1E28_0000, 0, 32'hFF, 0, 0);
        check("R11 past io err", r_err, 1);
        access(0, 32'hFCFF_FFFF, 0, 0, 0, 0);
        check("R11 below mem err", r_err, 1);
        access(0, 32'hFD00_0000, 3, 0, 0, 0);
        check("R11 size3 err", r_err, 1);
        check("R11 size3 no dn", r_saw, 0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule